// File: doc/BRIEF.md
# Pulse Tone Channel with Volume Envelope

This block produces one square-wave voice. A byte-wide write port programs a waveform shape, a volume envelope, and an 11-bit period. A write to the control register can also start the channel. A free-running period timer moves an eight-step position through the selected shape. While the shape bit at the current position is 1, the channel outputs its current 4-bit volume. At all other times it outputs zero.

An external frame sequencer supplies a one-cycle `env_tick` pulse at the envelope rate. The envelope ramps the volume up or down on those pulses. A separate length unit can silence the channel through `len_clear`. The channel's converter counts as powered only while the upper five bits of the envelope register are not all zero. Powering it down stops the channel at once.

All ports are plain control and status pins, so no valid/ready handshake is used. The write port is a register strobe with no back-pressure: it takes one write per cycle and holds off nothing. The sample output is a level and is valid in every cycle.

Top module: `sq_tone_channel`

## Requirements
- R1: Shape select `wr_data[7:6]` of a write with `wr_sel`=0 picks one of four 8-step patterns. Listed from step 0 to step 7, the patterns are: 0 → 00000001, 1 → 10000001, 2 → 10000111, 3 → 01111110. Bits 5:0 of that write belong to the external length unit.
- R2: Let P be the 11-bit period, with the low byte written at `wr_sel`=2 and bits 10:8 taken from `wr_data[2:0]` at `wr_sel`=3. While the channel is active, the step position advances by one every (2048−P)×4 clock cycles.
- R3: `sample` equals the current volume when the channel is active and the pattern bit at the current step is 1. Otherwise `sample` is 0.
- R4: A write with `wr_sel`=1 sets the following fields: pace from bits 2:0, direction from bit 3 (1 = up), and volume from bits 7:4. The new volume takes effect on the next cycle. The envelope runs only if the pace is nonzero; with pace 0, ticks leave the volume unchanged.
- R5: Each `env_tick` taken while the channel and the envelope are both running counts one step. When the count reaches the pace, the volume moves by one in the selected direction and the count restarts.
- R6: The volume saturates at 0 and 15. Once the volume reaches either limit, the envelope stops and further ticks leave the volume unchanged. The channel stays active.
- R7: The converter is powered when `wr_data[7:3]` of the last envelope write is nonzero. An envelope write with those bits all zero makes `active` low on the next cycle. A trigger issued while the converter is unpowered leaves the channel inactive.
- R8: A control write (`wr_sel`=3) with bit 7 set triggers the channel, provided the converter is powered. The trigger makes `active` high, restarts the step position at 0 with a fresh period count, reloads the volume from the envelope register, and restarts the envelope step count.
- R9: A `len_clear` pulse makes `active` low on the next cycle. If a trigger arrives in the same cycle, the trigger wins.
- R10: After reset, `active` is 0 and `sample` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 shape/length, 1 envelope, 2 period low, 3 period high/control |
| wr_data | input | 8 | Write data |
| env_tick | input | 1 | Envelope step pulse from the frame sequencer |
| len_clear | input | 1 | Stop request from the length unit |
| sample | output | 4 | Current amplitude |
| active | output | 1 | Channel running |

## Verification
Every write, tick or clear is registered on one rising edge. Its effect on `active` and `sample` is therefore due in the cycle that follows, and the bench reads both outputs at the next falling edge. The step position is counted from the trigger edge: c edges after the trigger, the position is floor(c/N) with N=(2048−P)×4. The bench derives its expected pattern bit from that cycle count and checks every falling edge across four full pattern periods. The envelope tests use period 0 together with shape 1. This keeps step 0 (bit 1) in place for 8192 cycles, so `sample` shows the raw volume on each tick.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int STEPS  = 8;
  localparam int STEP_W = $clog2(STEPS);

  typedef enum logic [1:0] {
    SEL_SHAPE = 2'd0,
    SEL_ENV   = 2'd1,
    SEL_PLO   = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  // Pattern bit for a shape at a step; step 0 is the leftmost listed bit.
  function automatic logic shape_bit(input logic [1:0] shape, input logic [STEP_W-1:0] step);
    logic [STEPS-1:0] pat;
    case (shape)
      2'd0:    pat = 8'b0000_0001;
      2'd1:    pat = 8'b1000_0001;
      2'd2:    pat = 8'b1000_0111;
      default: pat = 8'b0111_1110;
    endcase
    return pat[STEPS-1-int'(step)];
  endfunction
endpackage

// File: rtl/sq_step_timer.sv
module sq_step_timer #(
  parameter int PERIOD_W = 11,
  parameter int SCALE_SH = 2,
  parameter int STEP_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                restart,
  input  logic [PERIOD_W-1:0] period,
  output logic [STEP_W-1:0]   step
);
  localparam int CNT_W = PERIOD_W + SCALE_SH + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << PERIOD_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;

  assign reload = (FULL - CNT_W'(period)) << SCALE_SH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      step <= '0;
    end else if (restart) begin
      cnt  <= reload;
      step <= '0;
    end else if (run) begin
      if (cnt <= CNT_W'(1)) begin
        cnt  <= reload;
        step <= step + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(restart) && (step != $past(step))) |-> ($past(run) && step == STEP_W'($past(step) + 1'b1))) // R2
    else $error("step moved outside an expiry");
endmodule

// File: rtl/sq_envelope.sv
module sq_envelope #(
  parameter int VOL_W  = 4,
  parameter int PACE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [VOL_W-1:0]  load_vol,
  input  logic [PACE_W-1:0] load_pace,
  input  logic              load_up,
  input  logic              tick,
  input  logic              chan_on,
  output logic [VOL_W-1:0]  vol
);
  localparam logic [VOL_W-1:0] VOL_MAX = '1;

  logic              env_on;
  logic              up;
  logic [PACE_W-1:0] pace;
  logic [PACE_W-1:0] cnt;
  logic [PACE_W:0]   cnt_inc;
  logic [VOL_W-1:0]  vol_nx;

  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_comb begin
    vol_nx = vol;
    if (up && vol != VOL_MAX)        vol_nx = vol + 1'b1;
    else if (!up && vol != '0)       vol_nx = vol - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol    <= '0;
      env_on <= 1'b0;
      up     <= 1'b0;
      pace   <= '0;
      cnt    <= '0;
    end else if (load) begin
      vol    <= load_vol;
      pace   <= load_pace;
      up     <= load_up;
      cnt    <= '0;
      env_on <= (load_pace != '0);
    end else if (tick && chan_on && env_on) begin
      if (cnt_inc >= {1'b0, pace}) begin
        vol <= vol_nx;
        cnt <= '0;
        if (vol_nx == '0 || vol_nx == VOL_MAX) env_on <= 1'b0;
      end else begin
        cnt <= cnt_inc[PACE_W-1:0];
      end
    end
  end

  AST_VOL_MOVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && vol != $past(vol)) |-> (vol == $past(vol) + 1'b1 || vol == $past(vol) - 1'b1)) // R5
    else $error("volume jumped by more than one");

  AST_LIMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(env_on) && !$past(load)) |-> (vol == $past(vol))) // R6
    else $error("volume moved with envelope stopped");
endmodule

// File: rtl/sq_tone_channel.sv
module sq_tone_channel
  import sq_pkg::*;
#(
  parameter int PERIOD_W = 11,
  parameter int SCALE_SH = 2,
  parameter int VOL_W    = 4,
  parameter int PACE_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             env_tick,
  input  logic             len_clear,
  output logic [VOL_W-1:0] sample,
  output logic             active
);
  localparam int HI_W = PERIOD_W - 8;

  logic [1:0]          shape_q;
  logic [7:0]          env_q;
  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W-1:0] period_nx;
  logic                chan_on;
  logic                env_wr, ctrl_wr, plo_wr, shape_wr, trig;
  logic                dac_pwr;
  logic [STEP_W-1:0]   step;
  logic [VOL_W-1:0]    vol;
  logic [7:0]          env_src;

  assign shape_wr = wr_en && (wr_sel == SEL_SHAPE);
  assign env_wr   = wr_en && (wr_sel == SEL_ENV);
  assign plo_wr   = wr_en && (wr_sel == SEL_PLO);
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign trig     = ctrl_wr && wr_data[7];
  assign dac_pwr  = |env_q[7:3];

  always_comb begin
    period_nx = period_q;
    if (plo_wr)  period_nx[7:0] = wr_data;
    if (ctrl_wr) period_nx[PERIOD_W-1:8] = wr_data[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shape_q  <= '0;
      env_q    <= '0;
      period_q <= '0;
      chan_on  <= 1'b0;
    end else begin
      period_q <= period_nx;
      if (shape_wr) shape_q <= wr_data[7:6];
      if (env_wr)   env_q   <= wr_data;
      if (env_wr && wr_data[7:3] == '0) chan_on <= 1'b0;
      else if (trig)                    chan_on <= dac_pwr;
      else if (len_clear)               chan_on <= 1'b0;
    end
  end

  assign env_src = env_wr ? wr_data : env_q;

  sq_step_timer #(.PERIOD_W(PERIOD_W), .SCALE_SH(SCALE_SH), .STEP_W(STEP_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (chan_on),
    .restart (trig),
    .period  (period_nx),
    .step    (step)
  );

  sq_envelope #(.VOL_W(VOL_W), .PACE_W(PACE_W)) u_env (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (env_wr || trig),
    .load_vol  (env_src[7:4]),
    .load_pace (env_src[2:0]),
    .load_up   (env_src[3]),
    .tick      (env_tick),
    .chan_on   (chan_on),
    .vol       (vol)
  );

  assign active = chan_on;
  assign sample = (chan_on && shape_bit(shape_q, step)) ? vol : '0;

  AST_DAC_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (env_wr && wr_data[7:3] == '0) |=> !active) // R7
    else $error("channel active with converter off");

  AST_LEN_CLEAR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (len_clear && !trig) |=> !active) // R9
    else $error("length clear ignored");

  AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && dac_pwr) |=> (active && step == '0)) // R8
    else $error("trigger did not start channel");
endmodule

// File: tb/sq_tone_channel_bench.sv
module sq_tone_channel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       env_tick = 1'b0;
  logic       len_clear = 1'b0;
  logic [3:0] sample;
  logic       active;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sq_tone_channel u_sq_tone_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .env_tick(env_tick), .len_clear(len_clear), .sample(sample), .active(active)
  );

  function automatic logic pat_bit(input int shape, input int step);
    logic [7:0] p;
    case (shape)
      0: p = 8'b00000001;
      1: p = 8'b10000001;
      2: p = 8'b10000111;
      default: p = 8'b01111110;
    endcase
    return p[7 - (step % 8)];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    env_tick = 1'b1;
    @(negedge clk);
    env_tick = 1'b0;
  endtask

  task automatic start_slow(input logic [7:0] env);
    wr(2'd0, 8'h40);
    wr(2'd1, env);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h80);
  endtask

  task automatic t_reset();
    check("R10 active", active, 0);
    check("R10 sample", sample, 0);
  endtask

  task automatic t_shapes();
    for (int d = 0; d < 4; d++) begin
      wr(2'd0, 8'(d << 6));
      wr(2'd1, 8'hF0);
      wr(2'd2, 8'hFF);
      wr(2'd3, 8'h87);
      check("R8 active after trigger", active, 1);
      for (int c = 0; c < 32; c++) begin
        if (c > 0) @(negedge clk);
        check("R1 R3 shape sample", sample, pat_bit(d, c / 4) ? 15 : 0);
      end
    end
  endtask

  task automatic t_period();
    wr(2'd0, 8'h40);
    wr(2'd2, 8'hFE);
    wr(2'd3, 8'h87);
    for (int c = 0; c <= 16; c++) begin
      if (c > 0) @(negedge clk);
      if (c == 7)  check("R2 step0 end",   sample, 15);
      if (c == 8)  check("R2 step1 start", sample, 0);
      if (c == 16) check("R2 step2 start", sample, 0);
    end
  endtask

  task automatic t_env_up();
    start_slow(8'h2A);
    check("R4 initial volume", sample, 2);
    tick();
    check("R5 pace not reached", sample, 2);
    tick();
    check("R5 step up", sample, 3);
  endtask

  task automatic t_limits();
    start_slow(8'hE9);
    tick();
    check("R6 reach 15", sample, 15);
    tick();
    check("R6 hold 15", sample, 15);
    start_slow(8'h11);
    tick();
    check("R6 reach 0", sample, 0);
    check("R6 still active", active, 1);
    tick();
    check("R6 hold 0", sample, 0);
  endtask

  task automatic t_pace0();
    start_slow(8'h50);
    tick(); tick(); tick();
    check("R4 pace 0 holds", sample, 5);
    wr(2'd1, 8'h90);
    check("R4 write loads volume", sample, 9);
  endtask

  task automatic t_retrigger();
    start_slow(8'h31);
    tick();
    check("R5 step down", sample, 2);
    wr(2'd3, 8'h80);
    check("R8 volume reloaded", sample, 3);
  endtask

  task automatic t_dac();
    start_slow(8'h08);
    check("R7 dac on with bit3", active, 1);
    check("R7 volume zero", sample, 0);
    wr(2'd1, 8'h07);
    check("R7 dac off stops", active, 0);
    wr(2'd3, 8'h80);
    check("R7 trigger ignored", active, 0);
  endtask

  task automatic t_len_clear();
    start_slow(8'hF0);
    @(negedge clk);
    len_clear = 1'b1;
    @(negedge clk);
    len_clear = 1'b0;
    check("R9 clear stops", active, 0);
    check("R9 sample silent", sample, 0);
    @(negedge clk);
    len_clear = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h80;
    @(negedge clk);
    len_clear = 1'b0; wr_en = 1'b0;
    check("R9 trigger wins", active, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shapes();
    t_period();
    t_env_up();
    t_limits();
    t_pace0();
    t_retrigger();
    t_dac();
    t_len_clear();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1, 0);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule